// File: doc/BRIEF.md
# Subblock Repair Merge Multiplexer

This block sits on the data path of a cache that runs at very low supply voltage, where many storage cells fail. Each cache block is cut into equal-width subblocks. A defect map marks which subblocks of a block are broken. A separate lookup pairs each damaged block with a target block. On a read hit the multiplexer receives the primary block, the target block and the primary block's fault mask. It then assembles one clean block: each damaged subblock is taken from the target block and each healthy one from the primary block. The assembled block comes out one clock later, so the cache access grows by a single cycle.

At nominal voltage a bypass input is held high. The primary data then flows straight through in the same cycle and no repair takes place. The target block's own fault mask is also an input. If it is broken at any position that the merge takes from it, the result is flagged as bad. A write path works out, per subblock, whether the data goes to the primary copy or to the same position in the target block. Choosing the target block and filling the defect map are handled elsewhere.

Top module: `subblock_merge_mux`

## Requirements
- R1: In repair mode (bypass low), subblock k of the merged block equals subblock k of the target block when fault-mask bit k is 1, and subblock k of the primary block when bit k is 0. Subblock k occupies data bits [k*SUB_W +: SUB_W].
- R2: In repair mode, a read presented with valid high in cycle n appears on the read outputs, with valid high, right after clock edge n+1, which is exactly one register later.
- R3: With bypass high, the read data output equals the primary data input, the read valid output equals the read valid input in the same cycle, and the error flag is 0, whatever the fault masks hold.
- R4: In repair mode, the error flag that comes with a read result is 1 exactly when the primary mask and the target block's mask share a set bit.
- R5: On a repair-mode write, a subblock whose primary mask bit is 1 gets its target write enable and not its primary write enable. A subblock whose bit is 0 gets only its primary write enable. The two enable vectors never overlap.
- R6: On a write with bypass high, every primary write enable is 1 and every target write enable is 0. With write valid low, all enables are 0.
- R7: The subblock width is a parameter, and both 8-bit and 16-bit settings work on a 64-bit block.
- R8: During reset and right after it, the read valid output and the error flag are 0 in repair mode. A repair-mode cycle with read valid low gives valid 0 and error 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | 1 = nominal-voltage pass-through |
| rd_valid_i | input | 1 | Read hit data present |
| rd_prim_i | input | BLOCK_W | Primary block data |
| rd_tgt_i | input | BLOCK_W | Target block data |
| prim_mask_i | input | NSUB | Primary block fault mask, 1 = subblock faulty |
| tgt_mask_i | input | NSUB | Target block fault mask |
| rd_valid_o | output | 1 | Merged data valid |
| rd_data_o | output | BLOCK_W | Merged block |
| rd_err_o | output | 1 | Overlapping faults, merged data unusable |
| wr_valid_i | input | 1 | Write request |
| wr_mask_i | input | NSUB | Fault mask of the written primary block |
| wr_prim_en_o | output | NSUB | Per-subblock write enable, primary copy |
| wr_tgt_en_o | output | NSUB | Per-subblock write enable, target copy |

## Verification
The bench aims at subblock edges. It drives masks that are all zeros, all ones and a single bit. A design that takes the wrong slice width or reverses the mask polarity would return bytes from the wrong source at the edges. It tests both a shared fault and the one-bit-apart case: an error flag based on OR instead of AND, or one that ignores the target mask, goes wrong in one of the two. Bypass cycles follow right after repair cycles, which exposes a bypass that still goes through the register or still raises the flag. It also checks writes in both modes, which catches enable vectors that overlap or that are not gated by bypass.

// File: rtl/smm_pkg.sv
package smm_pkg;
    typedef enum logic {
        MODE_REPAIR = 1'b0,
        MODE_BYPASS = 1'b1
    } smm_mode_e;

    function automatic logic mask_clash(input logic [63:0] a, input logic [63:0] b);
        return |(a & b);
    endfunction
endpackage

// File: rtl/smm_sub_select.sv
module smm_sub_select #(
    parameter int BLOCK_W = 64,
    parameter int SUB_W   = 8,
    localparam int NSUB   = BLOCK_W / SUB_W
) (
    input  logic [BLOCK_W-1:0] prim_i,
    input  logic [BLOCK_W-1:0] tgt_i,
    input  logic [NSUB-1:0]    mask_i,
    output logic [BLOCK_W-1:0] data_o
);
    for (genvar k = 0; k < NSUB; k++) begin : g_sub
        assign data_o[k*SUB_W +: SUB_W] = mask_i[k] ? tgt_i[k*SUB_W +: SUB_W]
                                                    : prim_i[k*SUB_W +: SUB_W];
    end
endmodule

// File: rtl/smm_wr_scatter.sv
module smm_wr_scatter #(
    parameter int NSUB = 8
) (
    input  logic            wr_valid_i,
    input  logic            bypass_i,
    input  logic [NSUB-1:0] mask_i,
    output logic [NSUB-1:0] prim_en_o,
    output logic [NSUB-1:0] tgt_en_o
);
    for (genvar k = 0; k < NSUB; k++) begin : g_en
        assign tgt_en_o[k]  = wr_valid_i && !bypass_i && mask_i[k];
        assign prim_en_o[k] = wr_valid_i && (bypass_i || !mask_i[k]);
    end
endmodule

// File: rtl/subblock_merge_mux.sv
module subblock_merge_mux
    import smm_pkg::*;
#(
    parameter int BLOCK_W = 64,
    parameter int SUB_W   = 8,
    localparam int NSUB   = BLOCK_W / SUB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bypass_en,
    input  logic               rd_valid_i,
    input  logic [BLOCK_W-1:0] rd_prim_i,
    input  logic [BLOCK_W-1:0] rd_tgt_i,
    input  logic [NSUB-1:0]    prim_mask_i,
    input  logic [NSUB-1:0]    tgt_mask_i,
    output logic               rd_valid_o,
    output logic [BLOCK_W-1:0] rd_data_o,
    output logic               rd_err_o,
    input  logic               wr_valid_i,
    input  logic [NSUB-1:0]    wr_mask_i,
    output logic [NSUB-1:0]    wr_prim_en_o,
    output logic [NSUB-1:0]    wr_tgt_en_o
);
    typedef struct packed {
        logic               vld;
        logic               err;
        logic [BLOCK_W-1:0] data;
    } pipe_t;

    pipe_t              pipe_d, pipe_q;
    logic [BLOCK_W-1:0] merged;
    smm_mode_e          mode;
    logic               clash;

    assign mode = bypass_en ? MODE_BYPASS : MODE_REPAIR;

    smm_sub_select #(.BLOCK_W(BLOCK_W), .SUB_W(SUB_W)) u_sel (
        .prim_i (rd_prim_i),
        .tgt_i  (rd_tgt_i),
        .mask_i (prim_mask_i),
        .data_o (merged)
    );

    smm_wr_scatter #(.NSUB(NSUB)) u_wr (
        .wr_valid_i (wr_valid_i),
        .bypass_i   (bypass_en),
        .mask_i     (wr_mask_i),
        .prim_en_o  (wr_prim_en_o),
        .tgt_en_o   (wr_tgt_en_o)
    );

    always_comb begin
        clash       = mask_clash(64'(prim_mask_i), 64'(tgt_mask_i));
        pipe_d      = pipe_q;
        pipe_d.vld  = rd_valid_i && (mode == MODE_REPAIR);
        pipe_d.err  = pipe_d.vld && clash;
        if (pipe_d.vld) begin
            pipe_d.data = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    always_comb begin
        if (mode == MODE_BYPASS) begin
            rd_valid_o = rd_valid_i;
            rd_data_o  = rd_prim_i;
            rd_err_o   = 1'b0;
        end else begin
            rd_valid_o = pipe_q.vld;
            rd_data_o  = pipe_q.data;
            rd_err_o   = pipe_q.err;
        end
    end
endmodule

// File: rtl/smm_checker.sv
module smm_checker #(
    parameter int BLOCK_W = 64,
    parameter int SUB_W   = 8,
    localparam int NSUB   = BLOCK_W / SUB_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bypass_en,
    input logic               rd_valid_i,
    input logic [BLOCK_W-1:0] rd_prim_i,
    input logic [BLOCK_W-1:0] rd_tgt_i,
    input logic [NSUB-1:0]    prim_mask_i,
    input logic [NSUB-1:0]    tgt_mask_i,
    input logic               rd_valid_o,
    input logic [BLOCK_W-1:0] rd_data_o,
    input logic               rd_err_o,
    input logic               wr_valid_i,
    input logic [NSUB-1:0]    wr_prim_en_o,
    input logic [NSUB-1:0]    wr_tgt_en_o
);
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_en && $past(rd_valid_i && !bypass_en)) |-> rd_valid_o);

    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_en |-> (rd_data_o == rd_prim_i && rd_valid_o == rd_valid_i && !rd_err_o));

    assert_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_en && $past(rd_valid_i && !bypass_en && |(prim_mask_i & tgt_mask_i)))
        |-> rd_err_o);

    assert_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prim_en_o & wr_tgt_en_o) == '0);

    assert_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i |-> (wr_prim_en_o | wr_tgt_en_o) == {NSUB{1'b1}});

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid_i |-> (wr_prim_en_o == '0 && wr_tgt_en_o == '0));

    for (genvar k = 0; k < NSUB; k++) begin : g_sub
        assert_pick_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass_en && $past(rd_valid_i && !bypass_en))
            |-> rd_data_o[k*SUB_W +: SUB_W] ==
                ($past(prim_mask_i[k]) ? $past(rd_tgt_i[k*SUB_W +: SUB_W])
                                       : $past(rd_prim_i[k*SUB_W +: SUB_W])));
    end
endmodule

bind subblock_merge_mux smm_checker #(.BLOCK_W(BLOCK_W), .SUB_W(SUB_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bypass_en    (bypass_en),
    .rd_valid_i   (rd_valid_i),
    .rd_prim_i    (rd_prim_i),
    .rd_tgt_i     (rd_tgt_i),
    .prim_mask_i  (prim_mask_i),
    .tgt_mask_i   (tgt_mask_i),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .rd_err_o     (rd_err_o),
    .wr_valid_i   (wr_valid_i),
    .wr_prim_en_o (wr_prim_en_o),
    .wr_tgt_en_o  (wr_tgt_en_o)
);

// File: tb/subblock_merge_mux_tb.sv
module subblock_merge_mux_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    logic        byp, rv, wv;
    logic [63:0] prim, tgt;
    logic [7:0]  pm8, tm8, wm8;
    logic [3:0]  pm4, tm4, wm4;

    logic        v8, e8, v16, e16;
    logic [63:0] d8, d16;
    logic [7:0]  wp8, wt8;
    logic [3:0]  wp16, wt16;

    subblock_merge_mux #(.BLOCK_W(64), .SUB_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bypass_en(byp), .rd_valid_i(rv),
        .rd_prim_i(prim), .rd_tgt_i(tgt), .prim_mask_i(pm8), .tgt_mask_i(tm8),
        .rd_valid_o(v8), .rd_data_o(d8), .rd_err_o(e8),
        .wr_valid_i(wv), .wr_mask_i(wm8), .wr_prim_en_o(wp8), .wr_tgt_en_o(wt8));

    subblock_merge_mux #(.BLOCK_W(64), .SUB_W(16)) dut16_i (
        .clk(clk), .rst_n(rst_n), .bypass_en(byp), .rd_valid_i(rv),
        .rd_prim_i(prim), .rd_tgt_i(tgt), .prim_mask_i(pm4), .tgt_mask_i(tm4),
        .rd_valid_o(v16), .rd_data_o(d16), .rd_err_o(e16),
        .wr_valid_i(wv), .wr_mask_i(wm4), .wr_prim_en_o(wp16), .wr_tgt_en_o(wt16));

    function automatic logic [63:0] exp_merge(logic [63:0] p, logic [63:0] t,
                                              logic [7:0] m, int sw);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = m[i / sw] ? t[i] : p[i];
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full cycle: drive at negedge, check combinational outputs, then registered ones.
    task automatic step(logic b, logic r, logic w, logic [63:0] p, logic [63:0] t,
                        logic [7:0] a8, logic [7:0] b8, logic [7:0] c8,
                        logic [3:0] a4, logic [3:0] b4, logic [3:0] c4);
        @(negedge clk);
        byp = b; rv = r; wv = w; prim = p; tgt = t;
        pm8 = a8; tm8 = b8; wm8 = c8; pm4 = a4; tm4 = b4; wm4 = c4;
        #1;
        if (!w) begin
            chk("R6 idle en8", {wp8, wt8}, 16'h0);
            chk("R6 idle en16", {wp16, wt16}, 8'h0);
        end else if (b) begin
            chk("R6 bypass en8", {wp8, wt8}, {8'hFF, 8'h00});
            chk("R6 bypass en16", {wp16, wt16}, {4'hF, 4'h0});
        end else begin
            chk("R5 en8", {wp8, wt8}, {~c8, c8});
            chk("R5 en16", {wp16, wt16}, {~c4, c4});
        end
        if (b) begin
            chk("R3 bypass sub8", {v8, e8, d8}, {r, 1'b0, p});
            chk("R3 bypass sub16", {v16, e16, d16}, {r, 1'b0, p});
        end
        @(posedge clk); #1;
        if (!b) begin
            if (r) begin
                chk("R1 R7 data sub8", d8, exp_merge(p, t, a8, 8));
                chk("R1 R7 data sub16", d16, exp_merge(p, t, {4'h0, a4}, 16));
                chk("R2 R4 vld/err sub8", {v8, e8}, {1'b1, |(a8 & b8)});
                chk("R2 R4 vld/err sub16", {v16, e16}, {1'b1, |(a4 & b4)});
            end else begin
                chk("R8 idle sub8", {v8, e8}, 2'b00);
                chk("R8 idle sub16", {v16, e16}, 2'b00);
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        byp = 0; rv = 0; wv = 0; prim = '0; tgt = '0;
        pm8 = '0; tm8 = '0; wm8 = '0; pm4 = '0; tm4 = '0; wm4 = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset", {v8, e8, v16, e16}, 4'b0000);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R8 after reset", {v8, e8, v16, e16}, 4'b0000);

        // directed corners
        step(0, 1, 1, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD,
             8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 4'h0);
        step(0, 1, 1, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD,
             8'hFF, 8'h00, 8'hFF, 4'hF, 4'h0, 4'hF);
        step(0, 1, 1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
             8'h80, 8'h01, 8'h01, 4'h8, 4'h1, 4'h8);
        step(0, 1, 0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
             8'h81, 8'h01, 8'h00, 4'h9, 4'h1, 4'h0);
        step(0, 1, 0, 64'hDEAD_BEEF_0000_FFFF, 64'h5555_AAAA_5555_AAAA,
             8'h10, 8'h20, 8'h00, 4'h2, 4'h4, 4'h0);
        step(1, 1, 1, 64'hCAFE_F00D_1234_5678, 64'h0,
             8'hFF, 8'hFF, 8'h5A, 4'hF, 4'hF, 4'h5);
        step(0, 0, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
             8'hFF, 8'hFF, 8'h00, 4'hF, 4'hF, 4'h0);
        step(1, 0, 0, 64'h7777, 64'h0, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 4'h0);

        // constrained random
        void'($urandom(32'd1234));
        for (int it = 0; it < 400; it++) begin
            logic [7:0] a8, b8, c8;
            logic [3:0] a4, b4, c4;
            a8 = 8'($urandom); b8 = 8'($urandom) & ((it % 3 == 0) ? 8'hFF : ~a8);
            c8 = 8'($urandom);
            a4 = 4'($urandom); b4 = 4'($urandom) & ((it % 3 == 0) ? 4'hF : ~a4);
            c4 = 4'($urandom);
            step(($urandom % 5) == 0, ($urandom % 4) != 0, $urandom % 2 == 1,
                 {$urandom, $urandom}, {$urandom, $urandom}, a8, b8, c8, a4, b4, c4);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule